// File: doc/BRIEF.md
# Interrupt Route Resolver with Selectable Field Encoding

This block resolves, for every external interrupt source of an extended I/O interrupt controller, which CPU and which CPU interrupt pin that source is steered to. Each source owns a 12-bit route word holding an 8-bit CPU field and a 4-bit pin field. Software programs the route words and a mode register over a simple register bus. The block presents, per source, a registered CPU index, a pin index and a valid flag to the delivery fabric that follows it.

Two decoding schemes exist for each field. The legacy scheme, active after reset, reads the low CPU nibble and the pin field as one-hot bitmaps. This reaches four CPUs per node (the high CPU nibble is the node number) and four pins. The binary scheme reads each field as a plain index, which reaches 256 CPUs and 16 pins. A read-only capability register reports which binary schemes the instance supports. The mode register enables each scheme separately, and only where it is supported.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset the mode register reads 0, every route word reads 0, and every valid, CPU and pin output is 0.
- R2: The capability register at address 0x000 reads bit0 = binary pin decode supported and bit1 = binary CPU decode supported, with all other bits zero. A write to it changes no register and no output.
- R3: The mode register at address 0x004 has bit0 = binary pin decode enable and bit1 = binary CPU decode enable. A bit whose capability bit is 0 always reads 0 and has no effect on decoding.
- R4: The route word of source i is at address 0x100 + 4*i. The pin field is in bits [11:8] and the CPU field in bits [7:0]. It reads back as written, and bits above 11 read 0.
- R5: With binary CPU decode off, the CPU index is node*4 + b. Here node is CPU field bits [7:4] and b is the position of the lowest set bit in CPU field bits [3:0].
- R6: With binary pin decode off, the pin index is the position of the lowest set bit in the pin field.
- R7: In legacy decoding, an all-zero bitmap (CPU bits [3:0] or pin field) makes the source invalid. An invalid source drives CPU and pin outputs of 0.
- R8: With binary CPU decode on, the CPU index equals the 8-bit CPU field, so CPU field 0 is a valid target.
- R9: With binary pin decode on, the pin index equals the 4-bit pin field, so pin field 0 is a valid target.
- R10: A source is valid only while its interrupt input is high. Outputs are registered: they change on the first clock edge after the edge that takes a route or mode write, or that samples an input change.
- R11: The two decode choices act independently. Each field follows only its own mode bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register byte address for read and write |
| wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data for `addr` (combinational) |
| irq_in | input | NUM_SRC | Level interrupt inputs, one per source |
| route_cpu | output | NUM_SRC*8 | Resolved CPU index, 8 bits per source |
| route_pin | output | NUM_SRC*4 | Resolved pin index, 4 bits per source |
| route_vld | output | NUM_SRC | Source is asserted and has a reachable target |

## Verification
On every cycle, the assertions check the following. Unsupported mode bits never become set. A mode write lands masked by the capability, and a capability write leaves all state alone. Route writes land in the addressed source only. A valid output always follows a high input. Invalid sources carry zero indexes. Legacy outputs stay inside their node-of-four and four-pin ranges, and binary CPU outputs copy the programmed field. The exact lowest-bit choice among several set bits, the node arithmetic, the one-edge output latency, the readback of the capability on an instance lacking CPU encoding, and the independence of the two mode bits are shown only by the bench scenarios.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int CPU_W = 8;
    localparam int PIN_W = 4;
    localparam int MAP_W = 4;

    typedef struct packed {
        logic [PIN_W-1:0] pin;
        logic [CPU_W-1:0] cpu;
    } route_t;

    // bit0: binary pin decode, bit1: binary CPU decode
    typedef struct packed {
        logic cpu_enc;
        logic pin_enc;
    } mode_t;

    typedef struct packed {
        logic             vld;
        logic [CPU_W-1:0] cpu;
        logic [PIN_W-1:0] pin;
    } target_t;

    // returns {found, index of lowest set bit}
    function automatic logic [2:0] low_bit4(input logic [MAP_W-1:0] v);
        logic [2:0] r;
        r = 3'b000;
        for (int k = MAP_W - 1; k >= 0; k--) begin
            if (v[k]) r = {1'b1, 2'(k)};
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
    import irq_route_pkg::*;
#(
    parameter int                NUM_SRC     = 8,
    parameter int                ADDR_W      = 12,
    parameter int                DATA_W      = 32,
    parameter bit                HAS_PIN_ENC = 1'b1,
    parameter bit                HAS_CPU_ENC = 1'b1,
    parameter logic [ADDR_W-1:0] CAP_ADDR    = 'h000,
    parameter logic [ADDR_W-1:0] MODE_ADDR   = 'h004,
    parameter logic [ADDR_W-1:0] ROUTE_BASE  = 'h100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_data,
    output mode_t             mode,
    output route_t            routes [NUM_SRC]
);

    localparam int                ROUTE_W   = $bits(route_t);
    localparam int                MODE_W    = $bits(mode_t);
    localparam int                IDX_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam logic [ADDR_W-1:0] ROUTE_END = ROUTE_BASE + ADDR_W'(4 * NUM_SRC);
    localparam mode_t             CAPS      = '{cpu_enc: HAS_CPU_ENC, pin_enc: HAS_PIN_ENC};

    typedef struct packed {
        mode_t                      mode;
        route_t [NUM_SRC-1:0]       route;
    } state_t;

    state_t            st_d, st_q;
    logic              hit_route;
    logic [IDX_W-1:0]  route_sel;
    logic              unused_hi;

    assign unused_hi = ^wdata[DATA_W-1:ROUTE_W];
    assign hit_route = (addr >= ROUTE_BASE) && (addr < ROUTE_END) && (addr[1:0] == 2'b00);
    assign route_sel = IDX_W'((addr - ROUTE_BASE) >> 2);

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (addr == MODE_ADDR) begin
                st_d.mode = mode_t'(wdata[MODE_W-1:0] & CAPS);
            end else if (hit_route) begin
                st_d.route[route_sel] = route_t'(wdata[ROUTE_W-1:0]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_data = '0;
        if (addr == CAP_ADDR)       rd_data[MODE_W-1:0]  = CAPS;
        else if (addr == MODE_ADDR) rd_data[MODE_W-1:0]  = st_q.mode;
        else if (hit_route)         rd_data[ROUTE_W-1:0] = st_q.route[route_sel];
    end

    assign mode = st_q.mode;
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_out
        assign routes[g] = st_q.route[g];

        // R4: a route write lands in the addressed source
        a_r4_route_write: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && hit_route && route_sel == IDX_W'(g))
            |=> (st_q.route[g] == $past(wdata[ROUTE_W-1:0])));
    end

    a_r3_mode_masked: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.mode & ~CAPS) == '0));

    a_r3_mode_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == MODE_ADDR)
        |=> (st_q.mode == ($past(wdata[MODE_W-1:0]) & CAPS)));

    a_r2_cap_read_only: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == CAP_ADDR) |=> $stable(st_q));

endmodule

// File: rtl/irq_route_decode.sv
module irq_route_decode
    import irq_route_pkg::*;
(
    input  mode_t   mode,
    input  route_t  route,
    input  logic    irq,
    output target_t tgt
);

    logic [2:0]       cpu_low, pin_low;
    logic             cpu_ok, pin_ok, ok;
    logic [CPU_W-1:0] cpu_idx;
    logic [PIN_W-1:0] pin_idx;

    always_comb begin
        cpu_low = low_bit4(route.cpu[MAP_W-1:0]);
        pin_low = low_bit4(route.pin);

        if (mode.cpu_enc) begin
            cpu_ok  = 1'b1;
            cpu_idx = route.cpu;
        end else begin
            cpu_ok  = cpu_low[2];
            cpu_idx = {2'b00, route.cpu[CPU_W-1:MAP_W], cpu_low[1:0]};
        end

        if (mode.pin_enc) begin
            pin_ok  = 1'b1;
            pin_idx = route.pin;
        end else begin
            pin_ok  = pin_low[2];
            pin_idx = {2'b00, pin_low[1:0]};
        end

        ok      = irq & cpu_ok & pin_ok;
        tgt.vld = ok;
        tgt.cpu = ok ? cpu_idx : '0;
        tgt.pin = ok ? pin_idx : '0;
    end

endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
    import irq_route_pkg::*;
#(
    parameter int NUM_SRC     = 8,
    parameter int ADDR_W      = 12,
    parameter int DATA_W      = 32,
    parameter bit HAS_PIN_ENC = 1'b1,
    parameter bit HAS_CPU_ENC = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    output logic [DATA_W-1:0]        rd_data,
    input  logic [NUM_SRC-1:0]       irq_in,
    output logic [NUM_SRC*CPU_W-1:0] route_cpu,
    output logic [NUM_SRC*PIN_W-1:0] route_pin,
    output logic [NUM_SRC-1:0]       route_vld
);

    typedef struct packed {
        target_t [NUM_SRC-1:0] tgt;
    } out_t;

    mode_t   mode;
    route_t  routes  [NUM_SRC];
    target_t dec_tgt [NUM_SRC];
    out_t    out_d, out_q;

    irq_route_regs #(
        .NUM_SRC     (NUM_SRC),
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .HAS_PIN_ENC (HAS_PIN_ENC),
        .HAS_CPU_ENC (HAS_CPU_ENC)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rd_data (rd_data),
        .mode    (mode),
        .routes  (routes)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        irq_route_decode u_dec (
            .mode  (mode),
            .route (routes[g]),
            .irq   (irq_in[g]),
            .tgt   (dec_tgt[g])
        );

        assign route_vld[g]              = out_q.tgt[g].vld;
        assign route_cpu[g*CPU_W +: CPU_W] = out_q.tgt[g].cpu;
        assign route_pin[g*PIN_W +: PIN_W] = out_q.tgt[g].pin;

        a_r10_vld_needs_irq: assert property (@(posedge clk) disable iff (!rst_n)
            out_q.tgt[g].vld |-> $past(irq_in[g]));

        a_r7_invalid_zero: assert property (@(posedge clk) disable iff (!rst_n)
            !out_q.tgt[g].vld |-> (out_q.tgt[g].cpu == '0 && out_q.tgt[g].pin == '0));

        a_r5_legacy_cpu_node: assert property (@(posedge clk) disable iff (!rst_n)
            (out_q.tgt[g].vld && !$past(mode.cpu_enc))
            |-> (out_q.tgt[g].cpu[CPU_W-1:CPU_W-2] == 2'b00
                 && out_q.tgt[g].cpu[CPU_W-3:2] == $past(routes[g].cpu[CPU_W-1:MAP_W])));

        a_r6_legacy_pin_range: assert property (@(posedge clk) disable iff (!rst_n)
            (out_q.tgt[g].vld && !$past(mode.pin_enc))
            |-> (out_q.tgt[g].pin[PIN_W-1:2] == 2'b00));

        a_r8_binary_cpu: assert property (@(posedge clk) disable iff (!rst_n)
            (out_q.tgt[g].vld && $past(mode.cpu_enc))
            |-> (out_q.tgt[g].cpu == $past(routes[g].cpu)));

        a_r9_binary_pin: assert property (@(posedge clk) disable iff (!rst_n)
            (out_q.tgt[g].vld && $past(mode.pin_enc))
            |-> (out_q.tgt[g].pin == $past(routes[g].pin)));
    end

    always_comb begin
        out_d = out_q;
        for (int i = 0; i < NUM_SRC; i++) begin
            out_d.tgt[i] = dec_tgt[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

endmodule

// File: tb/test_irq_route_ctrl.sv
module test_irq_route_ctrl;

    localparam int NS = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [NS-1:0] irq_in = '0;
    logic [31:0] rd_data, rd_data_l;
    logic [NS*8-1:0] route_cpu, route_cpu_l;
    logic [NS*4-1:0] route_pin, route_pin_l;
    logic [NS-1:0]   route_vld, route_vld_l;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    irq_route_ctrl #(.NUM_SRC(NS)) i_irq_route_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rd_data(rd_data), .irq_in(irq_in), .route_cpu(route_cpu),
        .route_pin(route_pin), .route_vld(route_vld));

    // instance without binary CPU decode support
    irq_route_ctrl #(.NUM_SRC(NS), .HAS_CPU_ENC(1'b0)) i_irq_route_ctrl_lim (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rd_data(rd_data_l), .irq_in(irq_in), .route_cpu(route_cpu_l),
        .route_pin(route_pin_l), .route_vld(route_vld_l));

    typedef struct packed {
        logic [1:0]  mode;
        logic [11:0] route;
        logic        irq;
        logic        vld;
        logic [7:0]  cpu;
        logic [3:0]  pin;
    } vec_t;

    localparam vec_t VECS [9] = '{
        {2'd0, 12'h436, 1'b1, 1'b1, 8'd13,  4'd2},   // R5 R6 node 3, lowest bit 1; pin bit 2
        {2'd0, 12'h81F, 1'b1, 1'b1, 8'd4,   4'd3},   // R5 R6 several bits set, lowest wins
        {2'd0, 12'h450, 1'b1, 1'b0, 8'd0,   4'd0},   // R7 empty CPU bitmap
        {2'd0, 12'h0A1, 1'b1, 1'b0, 8'd0,   4'd0},   // R7 empty pin bitmap
        {2'd1, 12'hB21, 1'b1, 1'b1, 8'd8,   4'd11},  // R9 R11 binary pin, legacy CPU
        {2'd2, 12'h2C8, 1'b1, 1'b1, 8'd200, 4'd1},   // R8 R11 binary CPU, legacy pin
        {2'd3, 12'hFFF, 1'b1, 1'b1, 8'd255, 4'd15},  // R8 R9 top of range
        {2'd0, 12'h436, 1'b0, 1'b0, 8'd0,   4'd0},   // R10 input low
        {2'd3, 12'h000, 1'b1, 1'b1, 8'd0,   4'd0}    // R8 R9 zero fields valid in binary
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a);
        @(negedge clk);
        addr = a;
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_rd(12'h004);
        check("R1 mode after reset", rd_data, 32'h0);
        bus_rd(12'h108);
        check("R1 route after reset", rd_data, 32'h0);
        check("R1 valid after reset", 32'(route_vld), 32'h0);
        check("R1 cpu after reset", route_cpu[31:0], 32'h0);

        // R2 capability register
        bus_rd(12'h000);
        check("R2 caps full", rd_data, 32'h3);
        check("R2 caps lim", rd_data_l, 32'h1);
        bus_wr(12'h000, 32'h0);
        bus_rd(12'h000);
        check("R2 caps after write", rd_data, 32'h3);
        bus_rd(12'h004);
        check("R2 mode untouched by caps write", rd_data, 32'h0);

        // table of R5..R11 vectors on source 2
        foreach (VECS[i]) begin
            bus_wr(12'h004, 32'(VECS[i].mode));
            bus_wr(12'h108, 32'(VECS[i].route));
            irq_in[2] = VECS[i].irq;
            @(negedge clk);
            check($sformatf("table vec %0d vld", i), 32'(route_vld[2]), 32'(VECS[i].vld));
            check($sformatf("table vec %0d cpu", i), 32'(route_cpu[16 +: 8]), 32'(VECS[i].cpu));
            check($sformatf("table vec %0d pin", i), 32'(route_pin[8 +: 4]), 32'(VECS[i].pin));
        end

        // R10 latency: after write edge output still old, one edge later new
        bus_wr(12'h108, 32'h5A7);
        check("R10 cpu not yet updated", 32'(route_cpu[16 +: 8]), 32'h0);
        @(negedge clk);
        check("R10 cpu updated", 32'(route_cpu[16 +: 8]), 32'hA7);
        check("R10 pin updated", 32'(route_pin[8 +: 4]), 32'h5);
        irq_in[2] = 1'b0;
        #1;
        check("R10 vld holds until edge", 32'(route_vld[2]), 32'h1);
        @(negedge clk);
        check("R10 vld drops after edge", 32'(route_vld[2]), 32'h0);

        // R3 unsupported mode bit on the limited instance
        bus_wr(12'h004, 32'h3);
        bus_rd(12'h004);
        check("R3 lim mode readback", rd_data_l, 32'h1);
        check("R3 full mode readback", rd_data, 32'h3);
        bus_wr(12'h108, 32'h1C8);
        irq_in[2] = 1'b1;
        @(negedge clk);
        check("R3 lim cpu legacy node 12", 32'(route_cpu_l[16 +: 8]), 32'd51);
        check("R3 lim pin binary", 32'(route_pin_l[8 +: 4]), 32'd1);
        check("R3 lim vld", 32'(route_vld_l[2]), 32'h1);
        check("R11 full cpu binary", 32'(route_cpu[16 +: 8]), 32'd200);

        // R4 readback and isolation
        bus_wr(12'h114, 32'hFFFF_F436);
        bus_rd(12'h114);
        check("R4 route readback masks high bits", rd_data, 32'h436);
        bus_rd(12'h108);
        check("R4 neighbour route unchanged", rd_data, 32'h1C8);
        check("R10 source 5 idle stays invalid", 32'(route_vld[5]), 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule